// File: doc/BRIEF.md
# I2C Slave Address Front End with General Call

This block is the address-recognition front end of an I2C slave. It samples the raw clock and data lines through synchronisers and watches for START and STOP conditions. After each START it shifts in the first byte and compares it against the programmed own address and, at the same time, against the fixed general-call address. When the byte is accepted it pulls SDA low for the acknowledge clock, copies the byte into a receive buffer with a buffer-full flag, and raises an interrupt flag when the acknowledge clock ends.

In 10-bit mode the first byte carries a fixed header with the two upper address bits. A match there raises the update-address flag and the second byte is compared against the lower eight address bits. A general call in 10-bit mode skips the second byte, leaves the update-address flag clear and goes straight to data. Once addressed, every further byte is acknowledged and loaded until the next START or STOP. The START and STOP status bits give software a bus-free indication.

Top module: `i2c_gc_detect`

## Requirements
- R1: A START (SDA falling while SCL is high, both seen through the synchronisers) sets `s_flag`, clears `p_flag`, clears `ua` and starts a fresh address byte, also when it arrives as a repeated START in the middle of a transfer.
- R2: With `ten_bit`=0, a first byte equal to {own_addr[6:0], 0} (address followed by R/W=0, MSB first) is acknowledged: `sda_pull` is 1 from the SCL falling edge that ends the 8th bit to the SCL falling edge that ends the 9th bit. The same address with R/W=1 is not acknowledged.
- R3: A first byte of 8'h00 is a general call and is acknowledged, loaded and flagged only while `gc_en`=1; with `gc_en`=0 it is treated as a mismatch.
- R4: For every accepted byte, `rx_data` takes the byte and `buf_full` is set on the SCL rising edge of its 8th bit.
- R5: `irq` is set on the SCL falling edge that ends the 9th clock of every accepted byte and stays set until `irq_clr`; when the set and `irq_clr` fall in the same cycle, the set wins.
- R6: `buf_rd` clears `buf_full`; when a load and `buf_rd` fall in the same cycle, the load wins.
- R7: With `ten_bit`=1, a first byte of {5'b11110, own_addr[9:8], 0} is acknowledged and sets `ua` at the end of its 9th clock; the second byte is acknowledged only if it equals own_addr[7:0], and `ua` clears on that byte's 8th bit whether or not it matched.
- R8: With `ten_bit`=1 and `gc_en`=1, a general call is acknowledged, `ua` stays 0 and the next byte is already received as data.
- R9: A mismatching address byte gets no acknowledge, no load and no interrupt, and all following bytes are ignored until the next START.
- R10: After a successful address phase, every data byte is acknowledged, loaded into `rx_data` and raises `irq`.
- R11: A STOP (SDA rising while SCL is high) sets `p_flag`, clears `s_flag` and `ua`, releases SDA and abandons any byte in progress, so the next START begins a clean address byte.
- R12: `bus_free` is 1 when `p_flag` is set or when both `p_flag` and `s_flag` are clear; after reset both are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| own_addr | input | 10 | Own slave address (bits 6:0 used in 7-bit mode) |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| gc_en | input | 1 | 1 enables recognition of the general call |
| buf_rd | input | 1 | Receive buffer read strobe, clears buffer-full |
| irq_clr | input | 1 | Clears the interrupt flag |
| sda_pull | output | 1 | 1 drives SDA low (acknowledge) |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| irq | output | 1 | Interrupt flag |
| ua | output | 1 | Update-address flag (10-bit first byte matched) |
| s_flag | output | 1 | START seen since last STOP |
| p_flag | output | 1 | STOP seen since last START |
| bus_free | output | 1 | Bus is free for a new transfer |

## Verification
Two pairs of functions can land in one cycle: a byte load against a buffer read, and an interrupt set against an interrupt clear. The bench holds `buf_rd` and `irq_clr` high across a whole accepted byte, so the load on the 8th rising edge and the set on the 9th falling edge each coincide with a clear. A behavioural reference model compared on every clock requires the flag to read 1 for exactly the cycle after the coinciding event and 0 from the next cycle on, and a closing check confirms both flags end clear.

// File: rtl/i2c_gc_pkg.sv
package i2c_gc_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 10;
    localparam int CNT_W    = 4;

    localparam logic [BYTE_W-1:0] GC_BYTE  = '0;
    localparam logic [4:0]        TEN_HDR  = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR1 = 3'd1,
        PH_ADDR2 = 3'd2,
        PH_DATA  = 3'd3,
        PH_SKIP  = 3'd4
    } phase_e;

    typedef struct packed {
        logic accept;
        logic to_addr2;
    } verdict_t;

    function automatic logic [BYTE_W-1:0] ten_header(input logic [1:0] hi);
        return {TEN_HDR, hi, 1'b0};
    endfunction

endpackage

// File: rtl/i2c_gc_sync.sv
module i2c_gc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign dout = chain[STAGES-1];
    assign prev = chain[STAGES];
endmodule

// File: rtl/i2c_gc_addr_match.sv
module i2c_gc_addr_match
    import i2c_gc_pkg::*;
(
    input  phase_e                   phase,
    input  logic [BYTE_W-1:0]        byte_in,
    input  logic [ADDR_W-1:0]        own_addr,
    input  logic                     ten_bit,
    input  logic                     gc_en,
    output verdict_t                 verdict
);
    logic gc_hit, short_hit, hdr_hit;

    always_comb begin
        gc_hit    = gc_en && (byte_in == GC_BYTE);
        short_hit = !ten_bit && (byte_in == {own_addr[6:0], 1'b0});
        hdr_hit   = ten_bit && (byte_in == ten_header(own_addr[9:8]));
        verdict   = '0;
        case (phase)
            PH_ADDR1: begin
                verdict.accept   = gc_hit || short_hit || hdr_hit;
                verdict.to_addr2 = hdr_hit && !gc_hit;
            end
            PH_ADDR2: verdict.accept = (byte_in == own_addr[7:0]);
            PH_DATA:  verdict.accept = 1'b1;
            default:  verdict = '0;
        endcase
    end
endmodule

// File: rtl/i2c_gc_detect.sv
module i2c_gc_detect
    import i2c_gc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [9:0]        own_addr,
    input  logic              ten_bit,
    input  logic              gc_en,
    input  logic              buf_rd,
    input  logic              irq_clr,
    output logic              sda_pull,
    output logic [7:0]        rx_data,
    output logic              buf_full,
    output logic              irq,
    output logic              ua,
    output logic              s_flag,
    output logic              p_flag,
    output logic              bus_free
);
    localparam int NLINES = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    // index 1 = SCL, index 0 = SDA
    logic [NLINES-1:0] raw_l, cur_l, old_l;
    assign raw_l = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .din (raw_l[g]),
                .dout(cur_l[g]),
                .prev(old_l[g])
            );
        end
    endgenerate

    logic start_evt, stop_evt, scl_rise, scl_fall;
    assign start_evt = cur_l[1] && old_l[1] &&  old_l[0] && !cur_l[0];
    assign stop_evt  = cur_l[1] && old_l[1] && !old_l[0] &&  cur_l[0];
    assign scl_rise  = cur_l[1] && !old_l[1];
    assign scl_fall  = !cur_l[1] && old_l[1];

    phase_e            phase, phase_nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              in_ninth, ack_pend, ua_pend;
    logic              active;
    logic [BYTE_W-1:0] byte_now;
    verdict_t          verdict;

    assign active   = (phase == PH_ADDR1) || (phase == PH_ADDR2) || (phase == PH_DATA);
    assign byte_now = {shreg, cur_l[0]};

    i2c_gc_addr_match u_match (
        .phase   (phase),
        .byte_in (byte_now),
        .own_addr(own_addr),
        .ten_bit (ten_bit),
        .gc_en   (gc_en),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            phase_nxt <= PH_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            in_ninth  <= 1'b0;
            ack_pend  <= 1'b0;
            ua_pend   <= 1'b0;
            sda_pull  <= 1'b0;
            rx_data   <= '0;
            buf_full  <= 1'b0;
            irq       <= 1'b0;
            ua        <= 1'b0;
            s_flag    <= 1'b0;
            p_flag    <= 1'b0;
        end else begin
            if (buf_rd)  buf_full <= 1'b0;
            if (irq_clr) irq      <= 1'b0;

            if (start_evt || stop_evt) begin
                s_flag   <= start_evt;
                p_flag   <= stop_evt;
                phase    <= start_evt ? PH_ADDR1 : PH_IDLE;
                bit_cnt  <= '0;
                in_ninth <= 1'b0;
                ack_pend <= 1'b0;
                ua_pend  <= 1'b0;
                sda_pull <= 1'b0;
                ua       <= 1'b0;
            end else if (active && scl_rise) begin
                if (bit_cnt == ACK_SLOT) begin
                    in_ninth <= 1'b1;
                end else begin
                    shreg   <= byte_now[BYTE_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        if (phase == PH_ADDR2) ua <= 1'b0;
                        ack_pend <= verdict.accept;
                        ua_pend  <= verdict.accept && verdict.to_addr2;
                        if (verdict.accept) begin
                            rx_data   <= byte_now;
                            buf_full  <= 1'b1;
                            phase_nxt <= verdict.to_addr2 ? PH_ADDR2 : PH_DATA;
                        end else begin
                            phase_nxt <= PH_SKIP;
                        end
                    end
                end
            end else if (active && scl_fall) begin
                if (in_ninth) begin
                    sda_pull <= 1'b0;
                    phase    <= phase_nxt;
                    bit_cnt  <= '0;
                    in_ninth <= 1'b0;
                    ack_pend <= 1'b0;
                    ua_pend  <= 1'b0;
                    if (ack_pend) irq <= 1'b1;
                    if (ua_pend)  ua  <= 1'b1;
                end else if (bit_cnt == ACK_SLOT) begin
                    sda_pull <= ack_pend;
                end
            end
        end
    end

    assign bus_free = p_flag || (!s_flag && !p_flag);

endmodule

// File: rtl/i2c_gc_detect_chk.sv
module i2c_gc_detect_chk
    import i2c_gc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_evt,
    input logic       stop_evt,
    input logic [2:0] phase,
    input logic       sda_pull,
    input logic       ua,
    input logic       irq,
    input logic       irq_clr,
    input logic       buf_full,
    input logic       buf_rd,
    input logic       s_flag,
    input logic       p_flag,
    input logic       bus_free
);
    AST_START_FLAGS: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (s_flag && !p_flag && !sda_pull)); // R1

    AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> (p_flag && !s_flag && !sda_pull && !ua)); // R11

    AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> bus_free); // R12

    AST_NO_PULL_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE || phase == PH_SKIP) |-> !sda_pull); // R9

    AST_UA_IN_SECOND_BYTE: assert property (@(posedge clk) disable iff (rst)
        ua |-> (phase == PH_ADDR2)); // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R5

    AST_BF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !buf_rd) |=> buf_full); // R6
endmodule

bind i2c_gc_detect i2c_gc_detect_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .phase    (phase),
    .sda_pull (sda_pull),
    .ua       (ua),
    .irq      (irq),
    .irq_clr  (irq_clr),
    .buf_full (buf_full),
    .buf_rd   (buf_rd),
    .s_flag   (s_flag),
    .p_flag   (p_flag),
    .bus_free (bus_free)
);

// File: tb/test_i2c_gc_detect.sv
module test_i2c_gc_detect;
    localparam int SYNC = 2;
    localparam int Q    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [9:0] own_addr = 10'h05A;
    logic ten_bit = 1'b0, gc_en = 1'b0, buf_rd = 1'b0, irq_clr = 1'b0;
    logic sda_pull, buf_full, irq, ua, s_flag, p_flag, bus_free;
    logic [7:0] rx_data;
    logic scl_i, sda_i;

    assign scl_i = m_scl;
    assign sda_i = m_sda & ~sda_pull;

    always #5 clk = ~clk;

    i2c_gc_detect #(.SYNC_STAGES(SYNC)) i_i2c_gc_detect (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .own_addr(own_addr), .ten_bit(ten_bit), .gc_en(gc_en),
        .buf_rd(buf_rd), .irq_clr(irq_clr),
        .sda_pull(sda_pull), .rx_data(rx_data), .buf_full(buf_full),
        .irq(irq), .ua(ua), .s_flag(s_flag), .p_flag(p_flag), .bus_free(bus_free)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    localparam int M_IDLE = 0, M_FIRST = 1, M_SECOND = 2, M_DATA = 3, M_DEAF = 4;
    logic [1:0] hist[$];
    int  m_st, m_next, nbits;
    int  acc;
    bit  in9, will_ack, will_ua, armed;
    bit  e_pull, e_bf, e_irq, e_ua, e_s, e_p;
    int  e_rx;

    function automatic bit own_short(int b);
        return !ten_bit && (b == {own_addr[6:0], 1'b0});
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist = {};
            for (int i = 0; i <= SYNC; i++) hist.push_back(2'b11);
            m_st = M_IDLE; nbits = 0; acc = 0; in9 = 0; will_ack = 0; will_ua = 0;
            e_pull = 0; e_bf = 0; e_irq = 0; e_ua = 0; e_s = 0; e_p = 0; e_rx = 0;
            m_next = M_IDLE; armed = 0;
        end else begin
            logic [1:0] c, p;
            hist.push_back({scl_i, sda_i});
            if (hist.size() > 8) void'(hist.pop_front());
            c = hist[hist.size()-1-SYNC];
            p = hist[hist.size()-2-SYNC];
            armed = 1;
            if (buf_rd) e_bf = 0;
            if (irq_clr) e_irq = 0;
            if (c[1] && p[1] && p[0] && !c[0]) begin
                e_s = 1; e_p = 0; m_st = M_FIRST; nbits = 0; in9 = 0;
                will_ack = 0; will_ua = 0; e_pull = 0; e_ua = 0;
            end else if (c[1] && p[1] && !p[0] && c[0]) begin
                e_s = 0; e_p = 1; m_st = M_IDLE; nbits = 0; in9 = 0;
                will_ack = 0; will_ua = 0; e_pull = 0; e_ua = 0;
            end else if (m_st == M_FIRST || m_st == M_SECOND || m_st == M_DATA) begin
                if (c[1] && !p[1]) begin
                    if (nbits == 8) in9 = 1;
                    else begin
                        acc = ((acc << 1) | int'(c[0])) & 8'hFF;
                        nbits++;
                        if (nbits == 8) begin
                            bit gc, hdr;
                            gc  = gc_en && (acc == 0);
                            hdr = ten_bit && (acc == {5'b11110, own_addr[9:8], 1'b0});
                            will_ua = 0;
                            if (m_st == M_FIRST) begin
                                will_ack = gc || own_short(acc) || hdr;
                                will_ua  = hdr && !gc;
                            end else if (m_st == M_SECOND) begin
                                will_ack = (acc == own_addr[7:0]);
                                e_ua = 0;
                            end else will_ack = 1;
                            if (will_ack) begin
                                e_rx = acc; e_bf = 1;
                                m_next = will_ua ? M_SECOND : M_DATA;
                            end else m_next = M_DEAF;
                        end
                    end
                end else if (!c[1] && p[1]) begin
                    if (in9) begin
                        e_pull = 0; m_st = m_next; nbits = 0; in9 = 0;
                        if (will_ack) e_irq = 1;
                        if (will_ua) e_ua = 1;
                        will_ack = 0; will_ua = 0;
                    end else if (nbits == 8) e_pull = will_ack;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && armed && !done) begin
            chk("R2 sda_pull", int'(sda_pull), int'(e_pull));
            chk("R4 rx_data", int'(rx_data), e_rx);
            chk("R6 buf_full", int'(buf_full), int'(e_bf));
            chk("R5 irq", int'(irq), int'(e_irq));
            chk("R7 ua", int'(ua), int'(e_ua));
            chk("R1 s_flag", int'(s_flag), int'(e_s));
            chk("R11 p_flag", int'(p_flag), int'(e_p));
            chk("R12 bus_free", int'(bus_free), int'(e_p || (!e_s && !e_p)));
        end
    end

    // ---------------- bus master tasks ----------------
    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start;
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_restart;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic bus_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        acked = !sda_i;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        bit a;
        wq(5);
        rst = 1'b0;
        wq(3);
        chk("R12 reset bus_free", int'(bus_free), 1);
        chk("R4 reset buf_full", int'(buf_full), 0);
        chk("R5 reset irq", int'(irq), 0);

        // general call disabled
        gc_en = 1'b0;
        bus_start;
        send_byte(8'h00, a); chk("R3 gc disabled ack", int'(a), 0);
        chk("R3 gc disabled irq", int'(irq), 0);
        send_byte(8'h55, a); chk("R9 byte after miss ack", int'(a), 0);
        bus_stop;
        chk("R11 p after stop", int'(p_flag), 1);
        chk("R12 free after stop", int'(bus_free), 1);

        // general call enabled, 7-bit
        gc_en = 1'b1;
        bus_start;
        chk("R12 busy after start", int'(bus_free), 0);
        send_byte(8'h00, a); chk("R3 gc ack", int'(a), 1);
        chk("R4 gc byte", int'(rx_data), 8'h00);
        chk("R5 irq after gc", int'(irq), 1);
        irq_clr = 1'b1; wq(1); irq_clr = 1'b0; wq(1);
        chk("R5 irq cleared", int'(irq), 0);
        buf_rd = 1'b1; wq(1); buf_rd = 1'b0; wq(1);
        chk("R6 buf_full cleared", int'(buf_full), 0);
        send_byte(8'hA5, a); chk("R10 data ack", int'(a), 1);
        chk("R10 data byte", int'(rx_data), 8'hA5);
        bus_stop;

        // own 7-bit address, repeated start with R/W=1
        bus_start;
        send_byte(8'hB4, a); chk("R2 own ack", int'(a), 1);
        send_byte(8'h3C, a); chk("R10 data ack", int'(a), 1);
        bus_restart;
        chk("R1 s after restart", int'(s_flag), 1);
        send_byte(8'hB5, a); chk("R2 read bit no ack", int'(a), 0);
        bus_stop;

        // wrong address
        bus_start;
        send_byte(8'hB6, a); chk("R9 wrong addr ack", int'(a), 0);
        send_byte(8'h00, a); chk("R9 ignored byte ack", int'(a), 0);
        chk("R9 buffer untouched", int'(rx_data), 8'h3C);
        bus_stop;

        // STOP in the middle of an address byte
        bus_start;
        for (int i = 7; i >= 4; i--) bus_bit(a ? 1'b0 : 1'b1);
        bus_stop;
        bus_start;
        send_byte(8'hB4, a); chk("R11 clean byte after stop", int'(a), 1);
        bus_stop;

        // 10-bit addressing
        ten_bit = 1'b1; own_addr = 10'h2C3;
        bus_start;
        send_byte(8'hF4, a); chk("R7 header ack", int'(a), 1);
        chk("R7 ua set", int'(ua), 1);
        send_byte(8'hC3, a); chk("R7 low byte ack", int'(a), 1);
        chk("R7 ua cleared", int'(ua), 0);
        send_byte(8'h11, a); chk("R10 data ack", int'(a), 1);
        bus_stop;
        bus_start;
        send_byte(8'hF4, a); chk("R7 header ack", int'(a), 1);
        send_byte(8'hC4, a); chk("R7 wrong low byte", int'(a), 0);
        chk("R7 ua cleared on miss", int'(ua), 0);
        bus_stop;

        // 10-bit general call
        bus_start;
        send_byte(8'h00, a); chk("R8 gc ack", int'(a), 1);
        chk("R8 ua stays clear", int'(ua), 0);
        send_byte(8'h77, a); chk("R8 data at once", int'(a), 1);
        chk("R8 data byte", int'(rx_data), 8'h77);
        bus_stop;

        // coinciding load/read and set/clear
        ten_bit = 1'b0; own_addr = 10'h05A;
        bus_start;
        buf_rd = 1'b1; irq_clr = 1'b1;
        send_byte(8'hB4, a); chk("R2 ack under strobes", int'(a), 1);
        chk("R6 buf_full after held read", int'(buf_full), 0);
        chk("R5 irq after held clear", int'(irq), 0);
        buf_rd = 1'b0; irq_clr = 1'b0;
        send_byte(8'h5E, a);
        chk("R6 load sets buf_full", int'(buf_full), 1);
        bus_stop;

        wq(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule